// File: doc/BRIEF.md
# Single-wire pulse-token transceiver

This block connects a digital controller to an open-drain, half-duplex, single-wire line on which every data bit is carried as a burst of short low pulses. On the receive side it synchronises and filters the line, recognises the long-low wake event that brings a sleeping device up, measures the first low pulse of each bit and, at the end of a fixed decoding window, reports the bit as a one (one falling edge seen) or a zero (two falling edges seen). Malformed tokens are reported on a separate framing strobe and never appear as data.

On the transmit side a single request with a bit value produces one bit window on the line: a single low pulse for a one, or two low pulses separated by a high gap of the same length for a zero. The line output is an active-low drive enable for an external open-drain pad. While the transmitter is enabled or busy, the receiver is held idle so that the block never decodes its own pulses. All timing is given in nanoseconds and converted to clock cycles from a clock-frequency parameter.

The controller above this block assembles bytes, interprets flags and checks block integrity; it also decides when the device should sleep and signals that with a sleep request.

Top module: `pulse_token_xcvr`

## Requirements
- R1: After reset the block is asleep (`awake_o`=0), the drive enable is released (`line_drv_n_o`=1), `tx_busy_o`=0 and no strobe (`rx_valid_o`, `rx_ferr_o`, `wake_o`) is raised.
- R2: While asleep, a filtered low of at least WAKE_LOW_NS (default 60 µs) followed by WAKE_HIGH_NS of continuous high produces exactly one `wake_o` pulse and sets `awake_o`=1; a low shorter than WAKE_LOW_NS produces no wake.
- R3: While asleep, high or low excursions shorter than GLITCH_SLEEP_NS (default 2 µs) are ignored, so a brief high gap inside a wake low does not break the wake.
- R4: While awake, a bit token consisting of a single low pulse of START_MIN_NS to START_MAX_NS (4.1–4.56 µs) is reported at the end of the RX_WIN_NS window as `rx_valid_o`=1 with `rx_bit_o`=1.
- R5: A valid start pulse followed within the window by exactly one further falling edge is reported as `rx_valid_o`=1 with `rx_bit_o`=0.
- R6: While awake, excursions shorter than GLITCH_AWAKE_NS (one clock at 50 MHz) are ignored: a one-cycle high inside a start pulse leaves the bit decoded as a one, and a one-cycle low on an idle line produces no strobe.
- R7: A first low pulse shorter than START_MIN_NS, or longer than START_MAX_NS but shorter than WAKE_LOW_NS, or a window with three or more falling edges, raises `rx_ferr_o` for one cycle and produces no `rx_valid_o`.
- R8: While awake, a low of at least WAKE_LOW_NS is treated as a new wake event (not a framing error): `awake_o` drops and one `wake_o` pulse follows after WAKE_HIGH_NS of high.
- R9: A `tx_req_i` accepted while `tx_en_i`=1 and `tx_busy_o`=0 holds `tx_busy_o` high for exactly TX_BIT_NS worth of cycles (3000 at defaults) and for `tx_bit_i`=1 drives the line low for exactly one TX_PULSE_NS pulse (217 cycles) starting in the first busy cycle.
- R10: For `tx_bit_i`=0 the line is driven low for two pulses of TX_PULSE_NS each, separated by a high gap of TX_PULSE_NS.
- R11: While `tx_en_i`=1 or `tx_busy_o`=1 no bit is decoded from the line, and `tx_req_i` while `tx_en_i`=0 is ignored.
- R12: `sleep_i` returns the block to sleep at once: `awake_o`=0 and bit tokens produce no `rx_valid_o` until a new wake event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Sampled level of the shared wire |
| sleep_i | input | 1 | Request from the controller to enter sleep |
| tx_en_i | input | 1 | Transmit direction enable; gates the receiver |
| tx_req_i | input | 1 | Start one outgoing bit window |
| tx_bit_i | input | 1 | Value of the outgoing bit, taken with tx_req_i |
| line_drv_n_o | output | 1 | Active-low open-drain pull-down enable |
| tx_busy_o | output | 1 | Outgoing bit window in progress |
| rx_valid_o | output | 1 | One-cycle strobe: a bit was decoded |
| rx_bit_o | output | 1 | Value of the last decoded bit |
| rx_ferr_o | output | 1 | One-cycle strobe: a token was malformed and dropped |
| wake_o | output | 1 | One-cycle strobe: wake event completed |
| awake_o | output | 1 | Block is awake and decoding bits |

## Verification
The hardest situation to reach is one where the glitch filter's sleeping threshold decides the outcome: a wake low that would be too short on either side of a high gap, but counts as one long low because the gap is under 2 µs. The stimulus splits the wake low into two halves of 30 and 32 µs around a 1 µs high gap and expects a wake, after first showing that a single 40 µs low gives none. The second hard case is a long low that starts as an apparent bit while awake and must turn into a new wake instead of a framing error; it is reached by holding the line low for 62 µs after a normal falling edge.

// File: rtl/ptok_pkg.sv
package ptok_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_WLOW,
    ST_SETTLE,
    ST_IDLE,
    ST_LOW1,
    ST_WIN
  } rx_state_e;

  // Converts a duration in nanoseconds to whole clock cycles, at least one.
  function automatic int unsigned ns_to_cyc(int unsigned clk_hz, int unsigned ns);
    longint unsigned prod;
    prod = (longint'(clk_hz) * longint'(ns)) / 64'd1_000_000_000;
    if (prod == 0) return 1;
    return int'(prod);
  endfunction

  // True when a first-pulse width (in cycles) lies inside the accepted range.
  function automatic logic start_in_range(int unsigned w, int unsigned lo, int unsigned hi);
    return (w >= lo) && (w <= hi);
  endfunction

  // True when the transmitter should pull the line low at window position pos.
  function automatic logic tx_low_at(int unsigned pos, logic b, int unsigned p);
    if (pos < p) return 1'b1;
    if (!b && pos >= 2 * p && pos < 3 * p) return 1'b1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/ptok_glitch_filter.sv
module ptok_glitch_filter #(
  parameter int unsigned N_AWAKE = 2,
  parameter int unsigned N_SLEEP = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic awake_i,
  output logic level_o,
  output logic fell_o
);
  localparam int unsigned FW = $clog2(N_SLEEP + 1);

  logic [1:0]    sync_q;
  logic          level_q;
  logic          prev_q;
  logic [FW-1:0] fcnt_q;
  logic [FW-1:0] lim;

  assign lim = awake_i ? FW'(N_AWAKE - 1) : FW'(N_SLEEP - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      level_q <= 1'b1;
      prev_q  <= 1'b1;
      fcnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      prev_q <= level_q;
      if (sync_q[1] != level_q) begin
        if (fcnt_q >= lim) begin
          level_q <= sync_q[1];
          fcnt_q  <= '0;
        end else begin
          fcnt_q <= fcnt_q + FW'(1);
        end
      end else begin
        fcnt_q <= '0;
      end
    end
  end

  assign level_o = level_q;
  assign fell_o  = prev_q & ~level_q;

  AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> ($past(sync_q[1]) == level_q)); // R6

endmodule

// File: rtl/ptok_rx_decoder.sv
module ptok_rx_decoder
  import ptok_pkg::*;
#(
  parameter int unsigned WAKE_LOW_C  = 3000,
  parameter int unsigned WAKE_HIGH_C = 50000,
  parameter int unsigned ST_MIN_C    = 205,
  parameter int unsigned ST_MAX_C    = 228,
  parameter int unsigned WIN_C       = 1500,
  parameter int unsigned CW          = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic fell_i,
  input  logic sleep_i,
  input  logic rx_gate_i,
  output logic awake_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  output logic rx_ferr_o,
  output logic wake_o
);
  localparam logic [CW-1:0] WLOW_LAST  = CW'(WAKE_LOW_C - 1);
  localparam logic [CW-1:0] WHIGH_LAST = CW'(WAKE_HIGH_C - 1);
  localparam logic [CW-1:0] WIN_LAST   = CW'(WIN_C - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] wcnt_q;
  logic [1:0]    ecnt_q;
  logic          in_awake;

  assign in_awake = (state_q == ST_IDLE) || (state_q == ST_LOW1) || (state_q == ST_WIN);
  assign awake_o  = in_awake;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_SLEEP;
      cnt_q      <= '0;
      wcnt_q     <= '0;
      ecnt_q     <= '0;
      rx_valid_o <= 1'b0;
      rx_bit_o   <= 1'b0;
      rx_ferr_o  <= 1'b0;
      wake_o     <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      rx_ferr_o  <= 1'b0;
      wake_o     <= 1'b0;
      if (sleep_i) begin
        state_q <= ST_SLEEP;
        cnt_q   <= '0;
      end else if (rx_gate_i && in_awake) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_SLEEP: begin
            if (!level_i) begin
              state_q <= ST_WLOW;
              cnt_q   <= CW'(1);
            end
          end
          ST_WLOW: begin
            if (level_i) begin
              state_q <= ST_SLEEP;
            end else if (cnt_q >= WLOW_LAST) begin
              state_q <= ST_SETTLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_SETTLE: begin
            if (!level_i) begin
              cnt_q <= '0;
            end else if (cnt_q >= WHIGH_LAST) begin
              wake_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_IDLE: begin
            if (fell_i) begin
              state_q <= ST_LOW1;
              cnt_q   <= CW'(1);
              wcnt_q  <= CW'(1);
              ecnt_q  <= 2'd1;
            end
          end
          ST_LOW1: begin
            wcnt_q <= wcnt_q + CW'(1);
            if (level_i) begin
              if (start_in_range(32'(cnt_q), ST_MIN_C, ST_MAX_C)) begin
                state_q <= ST_WIN;
              end else begin
                rx_ferr_o <= 1'b1;
                state_q   <= ST_IDLE;
              end
            end else if (cnt_q >= WLOW_LAST) begin
              state_q <= ST_SETTLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_WIN: begin
            if (fell_i && ecnt_q != 2'd3) ecnt_q <= ecnt_q + 2'd1;
            if (wcnt_q >= WIN_LAST) begin
              state_q <= ST_IDLE;
              if (ecnt_q == 2'd1) begin
                rx_valid_o <= 1'b1;
                rx_bit_o   <= 1'b1;
              end else if (ecnt_q == 2'd2) begin
                rx_valid_o <= 1'b1;
                rx_bit_o   <= 1'b0;
              end else begin
                rx_ferr_o <= 1'b1;
              end
            end else begin
              wcnt_q <= wcnt_q + CW'(1);
            end
          end
          default: state_q <= ST_SLEEP;
        endcase
      end
    end
  end

  AST_VALID_NOT_FERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && rx_ferr_o)); // R7
  AST_VALID_ONLY_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> awake_o); // R12
  AST_NO_RX_WHILE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_gate_i |=> !rx_valid_o); // R11
  AST_WAKE_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(level_i) && awake_o)); // R2
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R2

endmodule

// File: rtl/ptok_tx_pulser.sv
module ptok_tx_pulser
  import ptok_pkg::*;
#(
  parameter int unsigned PULSE_C = 217,
  parameter int unsigned BIT_C   = 3000,
  parameter int unsigned TW      = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_i,
  output logic busy_o,
  output logic drv_n_o
);
  localparam logic [TW-1:0] BIT_LAST = TW'(BIT_C - 1);

  logic          busy_q;
  logic          bit_q;
  logic [TW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bit_q  <= 1'b1;
      pos_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        bit_q  <= bit_i;
        pos_q  <= '0;
      end
    end else if (pos_q >= BIT_LAST) begin
      busy_q <= 1'b0;
    end else begin
      pos_q <= pos_q + TW'(1);
    end
  end

  assign busy_o  = busy_q;
  assign drv_n_o = ~(busy_q && tx_low_at(32'(pos_q), bit_q, PULSE_C));

  AST_TX_STARTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !drv_n_o); // R9
  AST_TX_BIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(bit_q)); // R10

endmodule

// File: rtl/pulse_token_xcvr.sv
module pulse_token_xcvr
  import ptok_pkg::*;
#(
  parameter int unsigned CLK_HZ          = 50_000_000,
  parameter int unsigned WAKE_LOW_NS     = 60_000,
  parameter int unsigned WAKE_HIGH_NS    = 1_000_000,
  parameter int unsigned START_MIN_NS    = 4_100,
  parameter int unsigned START_MAX_NS    = 4_560,
  parameter int unsigned RX_WIN_NS       = 30_000,
  parameter int unsigned TX_PULSE_NS     = 4_340,
  parameter int unsigned TX_BIT_NS       = 60_000,
  parameter int unsigned GLITCH_AWAKE_NS = 45,
  parameter int unsigned GLITCH_SLEEP_NS = 2_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic sleep_i,
  input  logic tx_en_i,
  input  logic tx_req_i,
  input  logic tx_bit_i,
  output logic line_drv_n_o,
  output logic tx_busy_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  output logic rx_ferr_o,
  output logic wake_o,
  output logic awake_o
);
  localparam int unsigned WLOW_C   = ns_to_cyc(CLK_HZ, WAKE_LOW_NS);
  localparam int unsigned WHIGH_C  = ns_to_cyc(CLK_HZ, WAKE_HIGH_NS);
  localparam int unsigned SMIN_C   = ns_to_cyc(CLK_HZ, START_MIN_NS);
  localparam int unsigned SMAX_C   = ns_to_cyc(CLK_HZ, START_MAX_NS);
  localparam int unsigned WIN_C    = ns_to_cyc(CLK_HZ, RX_WIN_NS);
  localparam int unsigned PULSE_C  = ns_to_cyc(CLK_HZ, TX_PULSE_NS);
  localparam int unsigned TBIT_C   = ns_to_cyc(CLK_HZ, TX_BIT_NS);
  localparam int unsigned GA_C     = ns_to_cyc(CLK_HZ, GLITCH_AWAKE_NS);
  localparam int unsigned GS_C     = ns_to_cyc(CLK_HZ, GLITCH_SLEEP_NS);
  localparam int unsigned RX_MAX_C = (WHIGH_C > WLOW_C) ?
                                     ((WHIGH_C > WIN_C) ? WHIGH_C : WIN_C) :
                                     ((WLOW_C > WIN_C) ? WLOW_C : WIN_C);
  localparam int unsigned RX_CW    = $clog2(RX_MAX_C + 1);
  localparam int unsigned TX_CW    = $clog2(TBIT_C + 1);

  logic level;
  logic fell;
  logic awake;
  logic rx_gate;
  logic tx_start;

  assign rx_gate  = tx_en_i | tx_busy_o;
  assign tx_start = tx_req_i & tx_en_i & ~tx_busy_o;
  assign awake_o  = awake;

  ptok_glitch_filter #(
    .N_AWAKE(GA_C),
    .N_SLEEP(GS_C)
  ) filt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (line_i),
    .awake_i(awake),
    .level_o(level),
    .fell_o (fell)
  );

  ptok_rx_decoder #(
    .WAKE_LOW_C (WLOW_C),
    .WAKE_HIGH_C(WHIGH_C),
    .ST_MIN_C   (SMIN_C),
    .ST_MAX_C   (SMAX_C),
    .WIN_C      (WIN_C),
    .CW         (RX_CW)
  ) rx_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .fell_i    (fell),
    .sleep_i   (sleep_i),
    .rx_gate_i (rx_gate),
    .awake_o   (awake),
    .rx_valid_o(rx_valid_o),
    .rx_bit_o  (rx_bit_o),
    .rx_ferr_o (rx_ferr_o),
    .wake_o    (wake_o)
  );

  ptok_tx_pulser #(
    .PULSE_C(PULSE_C),
    .BIT_C  (TBIT_C),
    .TW     (TX_CW)
  ) tx_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start),
    .bit_i  (tx_bit_i),
    .busy_o (tx_busy_o),
    .drv_n_o(line_drv_n_o)
  );

  AST_TX_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_o) |-> $past(tx_en_i)); // R11

endmodule

// File: tb/pulse_token_xcvr_tb_top.sv
module pulse_token_xcvr_tb_top;
  localparam int P    = 217;   // 4340 ns at 20 ns per cycle
  localparam int TXB  = 3000;  // 60 us
  localparam int BITT = 1900;  // 38 us host bit time

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_n = 1'b1;
  logic sleep = 1'b0, tx_en = 1'b0, tx_req = 1'b0, tx_bit = 1'b0;
  logic drv_n, busy, rx_valid, rx_bit, rx_ferr, wake, awake;
  logic line;

  int checks = 0, fails = 0;
  int n_valid = 0, n_ferr = 0, n_wake = 0;
  logic last_bit = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  assign line = host_n & drv_n;

  pulse_token_xcvr #(.WAKE_HIGH_NS(100_000)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .sleep_i(sleep),
    .tx_en_i(tx_en), .tx_req_i(tx_req), .tx_bit_i(tx_bit),
    .line_drv_n_o(drv_n), .tx_busy_o(busy), .rx_valid_o(rx_valid),
    .rx_bit_o(rx_bit), .rx_ferr_o(rx_ferr), .wake_o(wake), .awake_o(awake));

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin n_valid++; last_bit = rx_bit; end
      if (rx_ferr) n_ferr++;
      if (wake) n_wake++;
    end
  end

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(logic v, int n);
    host_n = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_one();
    hold(0, P); hold(1, BITT - P);
  endtask

  task automatic send_zero();
    hold(0, P); hold(1, P); hold(0, P); hold(1, BITT - 3 * P);
  endtask

  task automatic do_wake(string req);
    int w0 = n_wake;
    hold(0, 3100); hold(1, 5400);
    check(req, n_wake == w0 + 1, n_wake - w0, 1);
    check(req, awake == 1'b1, awake, 1);
  endtask

  task automatic t_reset();
    check("R1 drive released", drv_n == 1'b1, drv_n, 1);
    check("R1 asleep", awake == 1'b0, awake, 0);
    check("R1 not busy", busy == 1'b0, busy, 0);
    check("R1 no strobes", (n_valid + n_ferr + n_wake) == 0, n_valid + n_ferr + n_wake, 0);
  endtask

  task automatic t_short_wake();
    hold(0, 2000); hold(1, 6000);
    check("R2 short low no wake", n_wake == 0, n_wake, 0);
    check("R2 still asleep", awake == 1'b0, awake, 0);
  endtask

  task automatic t_sleep_glitch_wake();
    hold(0, 1500); hold(1, 50); hold(0, 1600); hold(1, 5400);
    check("R3 bridged wake", n_wake == 1, n_wake, 1);
    check("R3 awake", awake == 1'b1, awake, 1);
  endtask

  task automatic t_bits();
    int v0 = n_valid;
    send_one();
    check("R4 one valid", n_valid == v0 + 1, n_valid - v0, 1);
    check("R4 one value", last_bit == 1'b1, last_bit, 1);
    send_zero();
    check("R5 zero valid", n_valid == v0 + 2, n_valid - v0, 2);
    check("R5 zero value", last_bit == 1'b0, last_bit, 0);
    // pattern 1,0,0,1: LSB-first 0x9 from the byte layer
    for (int i = 0; i < 4; i++) begin
      logic b = (i == 0 || i == 3);
      if (b) send_one(); else send_zero();
      check("R4 R5 pattern bit", last_bit == b, last_bit, b);
    end
    check("R4 R5 pattern count", n_valid == v0 + 6, n_valid - v0, 6);
    check("R7 no ferr on good bits", n_ferr == 0, n_ferr, 0);
  endtask

  task automatic t_awake_glitch();
    int v0 = n_valid, f0 = n_ferr;
    hold(0, 100); hold(1, 1); hold(0, P - 101); hold(1, BITT - P);
    check("R6 glitched start still one", n_valid == v0 + 1 && last_bit == 1'b1,
          n_valid - v0, 1);
    hold(0, 1); hold(1, BITT);
    check("R6 idle low glitch ignored", n_valid == v0 + 1 && n_ferr == f0,
          n_valid - v0 + n_ferr - f0, 1);
  endtask

  task automatic t_framing();
    int v0 = n_valid, f0 = n_ferr;
    hold(0, 500); hold(1, BITT);
    check("R7 long start ferr", n_ferr == f0 + 1, n_ferr - f0, 1);
    hold(0, 125); hold(1, BITT);
    check("R7 short start ferr", n_ferr == f0 + 2, n_ferr - f0, 2);
    hold(0, P); hold(1, P); hold(0, P); hold(1, P); hold(0, P); hold(1, BITT);
    check("R7 three edges ferr", n_ferr == f0 + 3, n_ferr - f0, 3);
    check("R7 no valid on bad tokens", n_valid == v0, n_valid - v0, 0);
  endtask

  task automatic t_rewake();
    int f0 = n_ferr;
    hold(0, 3100);
    check("R8 awake drops on long low", awake == 1'b0, awake, 0);
    hold(1, 5400);
    check("R8 rewake strobe", n_wake == 2, n_wake, 2);
    check("R8 no ferr", n_ferr == f0, n_ferr - f0, 0);
    check("R8 awake again", awake == 1'b1, awake, 1);
  endtask

  task automatic tx_bit_run(logic b, output int nbusy, output int nruns,
                            output int w1, output int gap, output int w2);
    logic prev = 1'b1;
    int hi = 0;
    nbusy = 0; nruns = 0; w1 = 0; gap = 0; w2 = 0;
    tx_en = 1'b1; tx_bit = b; tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    while (busy && nbusy < 2 * TXB) begin
      nbusy++;
      if (!drv_n) begin
        if (prev) nruns++;
        if (nruns == 1) w1++; else w2++;
      end else if (nruns == 1) begin
        hi++;
      end
      prev = drv_n;
      @(negedge clk);
    end
    gap = (nruns == 2) ? hi : 0;
    tx_en = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_tx();
    int nb, nr, w1, g, w2;
    int v0 = n_valid;
    tx_bit_run(1'b1, nb, nr, w1, g, w2);
    check("R9 one busy length", nb == TXB, nb, TXB);
    check("R9 one pulse count", nr == 1, nr, 1);
    check("R9 one pulse width", w1 == P, w1, P);
    tx_bit_run(1'b0, nb, nr, w1, g, w2);
    check("R10 zero busy length", nb == TXB, nb, TXB);
    check("R10 zero pulse count", nr == 2, nr, 2);
    check("R10 zero first width", w1 == P, w1, P);
    check("R10 zero gap", g == P, g, P);
    check("R10 zero second width", w2 == P, w2, P);
    check("R11 own pulses not decoded", n_valid == v0, n_valid - v0, 0);
  endtask

  task automatic t_gate();
    int v0 = n_valid;
    tx_en = 1'b1;
    send_one();
    check("R11 host bit gated", n_valid == v0, n_valid - v0, 0);
    tx_en = 1'b0;
    tx_req = 1'b1; tx_bit = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    @(negedge clk);
    check("R11 req without enable ignored", busy == 1'b0 && drv_n == 1'b1, busy, 0);
    send_one();
    check("R11 decoding resumes", n_valid == v0 + 1, n_valid - v0, 1);
  endtask

  task automatic t_sleep();
    int v0 = n_valid;
    sleep = 1'b1;
    @(negedge clk);
    sleep = 1'b0;
    @(negedge clk);
    check("R12 asleep after request", awake == 1'b0, awake, 0);
    send_one(); send_zero();
    check("R12 no bits while asleep", n_valid == v0, n_valid - v0, 0);
    do_wake("R2 wake from sleep");
    send_zero();
    check("R12 bits after new wake", n_valid == v0 + 1 && last_bit == 1'b0, n_valid - v0, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_short_wake();
    t_sleep_glitch_wake();
    t_bits();
    t_awake_glitch();
    t_framing();
    t_rewake();
    t_tx();
    t_gate();
    t_sleep();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule